// File: doc/BRIEF.md
# USB Host Root-Port Controller

This block keeps track of a single host root port. It sees a device arrive and leave, drives bus reset and resume signalling for the minimum time the bus requires, and tells software what happened through a one-cycle event code. Software steers it with level commands for power, bus reset and resume, and with single-cycle strobes for disable, suspend and releasing the attach debounce lock. All signalling times are counted in ticks of an external millisecond strobe.

After an attach the port locks out further attach and detach reporting. Software waits for the line to settle, reads the connect sense, and then releases the lock. At that moment the current level is compared with the port's state again, so any bounce seen during the lock is dropped and never queued. Events from separate sources can arrive together. They are held and handed out one per cycle so that none is lost.

Top module: `usb_rootport_ctrl`

## Requirements
- R1: After reset the port is in the unpowered state, `event_code` is NONE and `sof_en`, `bus_reset`, `resume_active`, `dev_ls`, `dbnc_locked` and `reset_rejected` are low. State codes: 0 unpowered, 1 detached, 2 attached, 3 resetting, 4 enabled, 5 suspended, 6 resuming, 7 disabled.
- R2: With `pwr_en` low the port returns to state 0 one cycle later from any state. With `pwr_en` high the port leaves state 0 for state 1.
- R3: In state 1, with the lock clear and `conn_sense` high, the port moves to state 2. It raises event CONN (code 2) and sets `dbnc_locked`.
- R4: While `dbnc_locked` is high, changes of `conn_sense` change neither the state nor the events. A `sw_unlock` strobe clears the lock. In the following cycle the current `conn_sense` level is evaluated afresh.
- R5: A rising `sw_reset` with `chan_count` zero moves an attached or disabled port to state 3 with `bus_reset` high. The port leaves state 3 only when `sw_reset` is low and RST_MS ticks have been counted. It then enters state 4, sets `sof_en`, raises ENABLED (code 4) and latches `ls_sense` into `dev_ls`.
- R6: A rising `sw_reset` accepted in state 4, 5 or 6 enters state 3 at once with `sof_en` low and raises DISABLED (code 5).
- R7: A rising `sw_reset` while `chan_count` is nonzero pulses `reset_rejected` for one cycle and leaves the state unchanged.
- R8: `port_err` or `sw_disable` in state 4, 5 or 6 moves the port to state 7 with `sof_en` low and raises DISABLED (code 5).
- R9: `sw_suspend` in state 4 enters state 5 with `sof_en` low. `sw_resume` high in state 5 enters state 6 with `resume_active` high. The port returns to state 4 only after RES_MS ticks and with `sw_resume` low, and raises no event.
- R10: `wake_req` in state 5 enters state 6. The port ends resume by itself after RES_MS ticks, whatever level `sw_resume` has.
- R11: A rising `ovc_sense` raises OVRCUR (code 6). A falling `ovc_sense` raises OVRCUR_CLR (code 7).
- R12: With the lock clear and `conn_sense` low, any state from 2 to 7 goes to state 1. The port raises DISCONN (code 3), clears `dev_ls` and sets `dbnc_locked`.
- R13: A rising `chan_irq` raises CHAN (code 1). Events raised together are emitted one per cycle, lowest code first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| pwr_en | input | 1 | Port power command (level) |
| conn_sense | input | 1 | Debounced device-present sense |
| ovc_sense | input | 1 | Overcurrent sense |
| port_err | input | 1 | Babble or port-error strobe |
| ls_sense | input | 1 | Line speed sense, 1 = low speed |
| chan_irq | input | 1 | Summary of pending channel interrupts |
| chan_count | input | CH_W | Number of allocated channels |
| sw_reset | input | 1 | Bus reset command (level) |
| sw_disable | input | 1 | Disable strobe |
| sw_suspend | input | 1 | Suspend strobe |
| sw_resume | input | 1 | Resume command (level) |
| wake_req | input | 1 | Remote wakeup strobe |
| sw_unlock | input | 1 | Debounce lock release strobe |
| port_state | output | 3 | Port state code |
| event_code | output | 3 | Event code, 0 when no event |
| sof_en | output | 1 | Frame-start generation enabled |
| bus_reset | output | 1 | Bus reset being driven |
| resume_active | output | 1 | Resume signalling being driven |
| dev_ls | output | 1 | Latched device speed, 1 = low speed |
| dbnc_locked | output | 1 | Attach debounce lock set |
| reset_rejected | output | 1 | One-cycle reset rejection flag |

## Verification
The bench builds the block with RST_MS = 3, RES_MS = 5 and CH_W = 3. The short tick limits let the bench reach the exact cycle where reset and resume may end: it checks one tick short of the limit and then at the limit, for both the software-held and the self-timed cases. The narrow channel count is enough to show that a nonzero count blocks reset. Random toggling of the overcurrent and channel inputs exercises the event encoding many times over.

// File: rtl/rootport_pkg.sv
package rootport_pkg;

    typedef enum logic [2:0] {
        PS_OFF       = 3'd0,
        PS_DETACHED  = 3'd1,
        PS_ATTACHED  = 3'd2,
        PS_RESETTING = 3'd3,
        PS_ENABLED   = 3'd4,
        PS_SUSPENDED = 3'd5,
        PS_RESUMING  = 3'd6,
        PS_DISABLED  = 3'd7
    } port_state_e;

    typedef enum logic [2:0] {
        EV_NONE       = 3'd0,
        EV_CHAN       = 3'd1,
        EV_CONN       = 3'd2,
        EV_DISCONN    = 3'd3,
        EV_ENABLED    = 3'd4,
        EV_DISABLED   = 3'd5,
        EV_OVRCUR     = 3'd6,
        EV_OVRCUR_CLR = 3'd7
    } port_event_e;

    localparam int NUM_EVT = 8;

endpackage

// File: rtl/rootport_edge.sv
// Per-bit edge strobes; POL bit 1 picks the rising edge, 0 the falling edge.
module rootport_edge #(
    parameter int              WIDTH = 4,
    parameter logic [WIDTH-1:0] POL  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] pulse_o
);
    typedef struct packed {
        logic [WIDTH-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (POL[i]) begin : g_rise
            assign pulse_o[i] = lvl_i[i] & ~st_q.prev[i];
        end else begin : g_fall
            assign pulse_o[i] = ~lvl_i[i] & st_q.prev[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rootport_mstimer.sv
// Saturating millisecond counter, cleared on request.
module rootport_mstimer #(
    parameter int LIMIT = 20,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          tick_i,
    output logic [CW-1:0] count_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)
            st_d.cnt = '0;
        else if (tick_i && st_q.cnt < CW'(LIMIT))
            st_d.cnt = st_q.cnt + 1'b1;
    end

    assign count_o = st_q.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rootport_evq.sv
// Pending-event holder: one event emitted per cycle, lowest code first.
module rootport_evq
    import rootport_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:1] set_i,
    output port_event_e        evt_o
);
    typedef struct packed {
        logic [NUM_EVT-1:1] pend;
    } evq_st_t;

    evq_st_t            st_d, st_q;
    logic [2:0]         pick;
    logic [NUM_EVT-1:1] emit;

    always_comb begin
        pick = '0;
        for (int i = NUM_EVT - 1; i >= 1; i--) begin
            if (st_q.pend[i]) pick = 3'(i);
        end
        emit = '0;
        for (int i = 1; i < NUM_EVT; i++) begin
            if (pick == 3'(i)) emit[i] = 1'b1;
        end
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~emit) | set_i;
    end

    assign evt_o = port_event_e'(pick);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/usb_rootport_ctrl.sv
module usb_rootport_ctrl
    import rootport_pkg::*;
#(
    parameter int RST_MS = 10,
    parameter int RES_MS = 20,
    parameter int CH_W   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ms_tick,
    input  logic            pwr_en,
    input  logic            conn_sense,
    input  logic            ovc_sense,
    input  logic            port_err,
    input  logic            ls_sense,
    input  logic            chan_irq,
    input  logic [CH_W-1:0] chan_count,
    input  logic            sw_reset,
    input  logic            sw_disable,
    input  logic            sw_suspend,
    input  logic            sw_resume,
    input  logic            wake_req,
    input  logic            sw_unlock,
    output logic [2:0]      port_state,
    output logic [2:0]      event_code,
    output logic            sof_en,
    output logic            bus_reset,
    output logic            resume_active,
    output logic            dev_ls,
    output logic            dbnc_locked,
    output logic            reset_rejected
);
    localparam int TMAX = (RST_MS > RES_MS) ? RST_MS : RES_MS;
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        port_state_e state;
        logic        lock;
        logic        speed_ls;
        logic        rej;
        logic        auto_wake;
    } port_st_t;

    port_st_t           st_d, st_q;
    logic [3:0]         pulses;
    logic [TW-1:0]      ms_cnt;
    logic [NUM_EVT-1:1] ev_set;
    port_event_e        evt;
    logic               rst_rise, rst_go, attached, stop_req, reset_done, resume_done;

    // bit3 overcurrent rise, bit2 overcurrent fall, bit1 channel rise, bit0 reset rise
    rootport_edge #(.WIDTH(4), .POL(4'b1011)) edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   ({ovc_sense, ovc_sense, chan_irq, sw_reset}),
        .pulse_o (pulses)
    );

    rootport_mstimer #(.LIMIT(TMAX)) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (st_d.state != st_q.state),
        .tick_i  (ms_tick),
        .count_o (ms_cnt)
    );

    rootport_evq evq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ev_set),
        .evt_o (evt)
    );

    assign rst_rise    = pulses[0];
    assign rst_go      = rst_rise && (chan_count == '0);
    assign attached    = (st_q.state >= PS_ATTACHED);
    assign stop_req    = port_err || sw_disable;
    assign reset_done  = !sw_reset && (ms_cnt >= TW'(RST_MS));
    assign resume_done = (ms_cnt >= TW'(RES_MS)) && (st_q.auto_wake || !sw_resume);

    always_comb begin
        st_d     = st_q;
        st_d.rej = rst_rise && (chan_count != '0);
        ev_set   = '0;
        ev_set[EV_CHAN]       = pulses[1];
        ev_set[EV_OVRCUR]     = pulses[3];
        ev_set[EV_OVRCUR_CLR] = pulses[2];
        if (sw_unlock) st_d.lock = 1'b0;

        if (!pwr_en) begin
            st_d.state     = PS_OFF;
            st_d.lock      = 1'b0;
            st_d.speed_ls  = 1'b0;
            st_d.auto_wake = 1'b0;
        end else if (st_q.state == PS_OFF) begin
            st_d.state = PS_DETACHED;
        end else if (!st_q.lock && st_q.state == PS_DETACHED && conn_sense) begin
            st_d.state      = PS_ATTACHED;
            st_d.lock       = 1'b1;
            ev_set[EV_CONN] = 1'b1;
        end else if (!st_q.lock && attached && !conn_sense) begin
            st_d.state         = PS_DETACHED;
            st_d.lock          = 1'b1;
            st_d.speed_ls      = 1'b0;
            st_d.auto_wake     = 1'b0;
            ev_set[EV_DISCONN] = 1'b1;
        end else begin
            case (st_q.state)
                PS_ATTACHED, PS_DISABLED: begin
                    if (rst_go) st_d.state = PS_RESETTING;
                end
                PS_RESETTING: begin
                    if (reset_done) begin
                        st_d.state         = PS_ENABLED;
                        st_d.speed_ls      = ls_sense;
                        ev_set[EV_ENABLED] = 1'b1;
                    end
                end
                PS_ENABLED, PS_SUSPENDED, PS_RESUMING: begin
                    if (rst_go) begin
                        st_d.state          = PS_RESETTING;
                        st_d.auto_wake      = 1'b0;
                        ev_set[EV_DISABLED] = 1'b1;
                    end else if (stop_req) begin
                        st_d.state          = PS_DISABLED;
                        st_d.auto_wake      = 1'b0;
                        ev_set[EV_DISABLED] = 1'b1;
                    end else if (st_q.state == PS_ENABLED) begin
                        if (sw_suspend) st_d.state = PS_SUSPENDED;
                    end else if (st_q.state == PS_SUSPENDED) begin
                        if (sw_resume) begin
                            st_d.state     = PS_RESUMING;
                            st_d.auto_wake = 1'b0;
                        end else if (wake_req) begin
                            st_d.state     = PS_RESUMING;
                            st_d.auto_wake = 1'b1;
                        end
                    end else if (resume_done) begin
                        st_d.state     = PS_ENABLED;
                        st_d.auto_wake = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: PS_OFF, default: '0};
        else        st_q <= st_d;
    end

    assign port_state     = st_q.state;
    assign event_code     = evt;
    assign sof_en         = (st_q.state == PS_ENABLED);
    assign bus_reset      = (st_q.state == PS_RESETTING);
    assign resume_active  = (st_q.state == PS_RESUMING);
    assign dev_ls         = st_q.speed_ls;
    assign dbnc_locked    = st_q.lock;
    assign reset_rejected = st_q.rej;
endmodule

// File: rtl/rootport_chk.sv
module rootport_chk
    import rootport_pkg::*;
#(
    parameter int CH_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sw_reset,
    input logic            conn_sense,
    input logic [CH_W-1:0] chan_count,
    input logic [2:0]      port_state,
    input logic            resume_active,
    input logic            dbnc_locked,
    input logic            reset_rejected
);
    AST_REJECT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        reset_rejected |-> $past(chan_count) != '0); // R7

    AST_REJECT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_rejected |=> !reset_rejected); // R7

    AST_ENABLE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (port_state == PS_ENABLED && $past(port_state) == PS_RESETTING) |-> !$past(sw_reset)); // R5

    AST_ATTACH_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (port_state == PS_ATTACHED && $past(port_state) == PS_DETACHED)
            |-> (!$past(dbnc_locked) && dbnc_locked)); // R3

    AST_DETACH_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (port_state == PS_DETACHED && $past(port_state) >= PS_ATTACHED)
            |-> (!$past(conn_sense) && !$past(dbnc_locked))); // R12

    AST_RESUME_FROM_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_active && !$past(resume_active)) |-> $past(port_state) == PS_SUSPENDED); // R9
endmodule

bind usb_rootport_ctrl rootport_chk #(.CH_W(CH_W)) chk_i (.*);

// File: tb/usb_rootport_ctrl_tb_top.sv
module usb_rootport_ctrl_tb_top;
    localparam int RST_MS = 3;
    localparam int RES_MS = 5;
    localparam int CH_W   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 0, pwr_en = 0, conn_sense = 0, ovc_sense = 0, port_err = 0;
    logic ls_sense = 0, chan_irq = 0, sw_reset = 0, sw_disable = 0, sw_suspend = 0;
    logic sw_resume = 0, wake_req = 0, sw_unlock = 0;
    logic [CH_W-1:0] chan_count = '0;
    logic [2:0] port_state, event_code;
    logic sof_en, bus_reset, resume_active, dev_ls, dbnc_locked, reset_rejected;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    usb_rootport_ctrl #(.RST_MS(RST_MS), .RES_MS(RES_MS), .CH_W(CH_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pwr_en(pwr_en),
        .conn_sense(conn_sense), .ovc_sense(ovc_sense), .port_err(port_err),
        .ls_sense(ls_sense), .chan_irq(chan_irq), .chan_count(chan_count),
        .sw_reset(sw_reset), .sw_disable(sw_disable), .sw_suspend(sw_suspend),
        .sw_resume(sw_resume), .wake_req(wake_req), .sw_unlock(sw_unlock),
        .port_state(port_state), .event_code(event_code), .sof_en(sof_en),
        .bus_reset(bus_reset), .resume_active(resume_active), .dev_ls(dev_ls),
        .dbnc_locked(dbnc_locked), .reset_rejected(reset_rejected)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick_n(int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1;
            cyc();
            ms_tick = 1'b0;
        end
    endtask

    // expected event for a single toggle: overcurrent rise 6, fall 7; channel rise 1, fall none
    function automatic int exp_evt(bit is_ovc, bit lvl);
        if (is_ovc) return lvl ? 6 : 7;
        return lvl ? 1 : 0;
    endfunction

    initial begin
        repeat (3) cyc();
        check("R1 state", port_state, 0);
        check("R1 event", event_code, 0);
        check("R1 outputs", {sof_en, bus_reset, resume_active, dev_ls, dbnc_locked, reset_rejected}, 0);
        rst_n = 1'b1;
        cyc();
        check("R1 state after release", port_state, 0);

        pwr_en = 1'b1; cyc();
        check("R2 power on", port_state, 1);

        conn_sense = 1'b1; cyc();
        check("R3 attach state", port_state, 2);
        check("R3 CONN event", event_code, 2);
        check("R3 lock set", dbnc_locked, 1);
        cyc();
        check("R13 event drained", event_code, 0);

        conn_sense = 1'b0; cyc(); cyc();
        check("R4 locked ignores drop", port_state, 2);
        check("R4 no event while locked", event_code, 0);
        conn_sense = 1'b1; sw_unlock = 1'b1; cyc(); sw_unlock = 1'b0;
        check("R4 unlock clears", dbnc_locked, 0);
        cyc();
        check("R4 stable after unlock", port_state, 2);

        chan_count = 3'd2; sw_reset = 1'b1; cyc();
        check("R7 reject flag", reset_rejected, 1);
        check("R7 state kept", port_state, 2);
        cyc();
        check("R7 one cycle", reset_rejected, 0);
        sw_reset = 1'b0; chan_count = '0; cyc();

        ls_sense = 1'b1; sw_reset = 1'b1; cyc();
        check("R5 resetting", port_state, 3);
        check("R5 bus reset", bus_reset, 1);
        sw_reset = 1'b0;
        tick_n(RST_MS - 1); cyc();
        check("R5 held to minimum", port_state, 3);
        tick_n(1); cyc();
        check("R5 enabled", port_state, 4);
        check("R5 sof on", sof_en, 1);
        check("R5 ENABLED event", event_code, 4);
        check("R5 speed latched", dev_ls, 1);
        ls_sense = 1'b0;

        sw_reset = 1'b1; cyc();
        check("R6 reset from enabled", port_state, 3);
        check("R6 DISABLED event", event_code, 5);
        check("R6 sof off", sof_en, 0);
        tick_n(RST_MS); cyc();
        check("R5 waits for release", port_state, 3);
        sw_reset = 1'b0; cyc();
        check("R6 re-enabled", port_state, 4);
        check("R6 ENABLED event", event_code, 4);

        sw_suspend = 1'b1; cyc(); sw_suspend = 1'b0;
        check("R9 suspended", port_state, 5);
        check("R9 sof off", sof_en, 0);
        sw_resume = 1'b1; cyc();
        check("R9 resuming", port_state, 6);
        check("R9 resume active", resume_active, 1);
        tick_n(RES_MS); cyc();
        check("R9 held by software", port_state, 6);
        sw_resume = 1'b0; cyc();
        check("R9 back to enabled", port_state, 4);
        check("R9 no event", event_code, 0);

        sw_suspend = 1'b1; cyc(); sw_suspend = 1'b0;
        wake_req = 1'b1; cyc(); wake_req = 1'b0;
        check("R10 wake resuming", port_state, 6);
        sw_resume = 1'b1;
        tick_n(RES_MS);
        check("R10 still driving", resume_active, 1);
        cyc();
        check("R10 self release", port_state, 4);
        sw_resume = 1'b0;

        port_err = 1'b1; cyc(); port_err = 1'b0;
        check("R8 error disables", port_state, 7);
        check("R8 DISABLED event", event_code, 5);
        sw_reset = 1'b1; cyc();
        check("R5 reset from disabled", port_state, 3);
        check("R5 no event from disabled", event_code, 0);
        tick_n(RST_MS); sw_reset = 1'b0; cyc();
        check("R5 enabled again", port_state, 4);
        cyc();
        sw_disable = 1'b1; cyc(); sw_disable = 1'b0;
        check("R8 sw disable", port_state, 7);
        check("R8 sw DISABLED event", event_code, 5);

        chan_irq = 1'b1; ovc_sense = 1'b1; cyc();
        check("R13 CHAN first", event_code, 1);
        cyc();
        check("R11 OVRCUR", event_code, 6);
        cyc();
        check("R13 queue empty", event_code, 0);
        ovc_sense = 1'b0; cyc();
        check("R11 OVRCUR_CLR", event_code, 7);
        chan_irq = 1'b0; cyc();
        check("R13 no event on fall", event_code, 0);

        conn_sense = 1'b0; cyc();
        check("R12 detached", port_state, 1);
        check("R12 DISCONN event", event_code, 3);
        check("R12 speed cleared", dev_ls, 0);
        check("R12 lock set", dbnc_locked, 1);

        conn_sense = 1'b1; cyc(); cyc();
        check("R4 attach ignored while locked", port_state, 1);
        sw_unlock = 1'b1; cyc(); sw_unlock = 1'b0;
        check("R4 unlock", dbnc_locked, 0);
        cyc();
        check("R4 level re-evaluated", port_state, 2);
        check("R4 CONN after unlock", event_code, 2);

        pwr_en = 1'b0; cyc();
        check("R2 power off", port_state, 0);
        check("R2 sof off", sof_en, 0);

        void'($urandom(32'd4242));
        for (int i = 0; i < 150; i++) begin
            bit which;
            which = 1'($urandom % 2);
            if (which) ovc_sense = ~ovc_sense;
            else       chan_irq  = ~chan_irq;
            cyc();
            check(which ? "R11 random" : "R13 random", event_code,
                  exp_evt(which, which ? ovc_sense : chan_irq));
            cyc();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule